// File: doc/BRIEF.md
# Single-Level Page Table Translator

The translator turns a virtual address from a CPU into a physical address by looking up one flat page table held in main memory. A request carries a virtual address. The block splits that address into a virtual page number (the upper bits) and a page offset (the lowest `PAGE_BITS` bits). It computes where the entry sits in memory from a table base register and the page number, and fetches that entry through a simple read port.

Each entry holds a present flag and a physical page number. If the flag is set, the block returns the physical page number joined to the unchanged offset. If the flag is clear, the block reports a page fault and gives no address. The requester can then have the entry filled in elsewhere and present the same address again.

The block handles one translation at a time. It has no translation cache, so every request costs exactly one entry fetch. The base register selects the table of the running process. It can only change while the block is idle, so a table switch never disturbs a lookup that is in flight.

Top module: `pt_xlate`

## Requirements
- R1: After reset, `req_ready_o` is 1 while `resp_valid_o`, `resp_pa_valid_o`, `resp_fault_o` and `mem_req_valid_o` are 0.
- R2: The entry address driven on `mem_req_addr_o` equals the base register plus the virtual page number `req_va_i[VA_W-1:PAGE_BITS]` times `PTE_BYTES`.
- R3: An entry with bit `PTE_W-1` set to 1 is present. The response then has `resp_pa_valid_o`=1, `resp_fault_o`=0 and `resp_pa_o` = {entry bits `[PPN_W-1:0]`, `req_va_i[PAGE_BITS-1:0]`}.
- R4: An entry with bit `PTE_W-1` equal to 0 gives a response with `resp_fault_o`=1, `resp_pa_valid_o`=0 and `resp_pa_o`=0.
- R5: `resp_valid_o` is high for exactly one cycle per accepted request. `resp_pa_valid_o` and `resp_fault_o` are high only together with it, and exactly one of the two is high then.
- R6: `req_ready_o` is 0 from the cycle after a request is accepted up to and including the response cycle.
- R7: The block waits any number of cycles for `mem_req_ready_i` and for `mem_rdata_valid_i`. With no stalls the response appears 3 cycles after acceptance; each stall cycle adds one cycle.
- R8: A write through `base_we_i` takes effect only while `req_ready_o` is 1. A write attempted during a translation is ignored, both by that translation and by later ones.
- R9: After a fault, presenting the same virtual address once its entry has been made present yields a hit with the new physical page number.
- R10: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the next cycle still has `mem_req_valid_o` at 1 and `mem_req_addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Table base write strobe |
| base_d_i | input | MEM_AW | New table base byte address |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_va_i | input | VA_W | Virtual address |
| resp_valid_o | output | 1 | Response strobe |
| resp_pa_valid_o | output | 1 | Translation hit |
| resp_fault_o | output | 1 | Page fault |
| resp_pa_o | output | PA_W | Physical address (0 on fault) |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | MEM_AW | Entry byte address |
| mem_rdata_valid_i | input | 1 | Entry data valid |
| mem_rdata_i | input | PTE_W | Entry: present flag at MSB, page number below |

## Verification
The bench builds the block with a 12-bit virtual address, 16-byte pages, a 10-bit physical address, 12-bit memory addresses and 2-byte entries. This gives an 8-bit page number and a 6-bit physical page number. The whole 256-entry table fits in a small modelled memory, so the largest page number, the largest physical page and the entry-size scaling can all be observed directly. Short delays on the memory ready and on the returned data make the stall timing of R7 easy to predict cycle by cycle.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_e;
endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] d_i,
  input  logic          idle_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             q_o <= '0;
    else if (we_i && idle_i) q_o <= d_i;
  end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int VPN_W     = 20,
  parameter int AW        = 32,
  parameter int PTE_BYTES = 4
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [AW-1:0]    base_i,
  output logic [AW-1:0]    addr_o
);
  localparam int SHIFT = $clog2(PTE_BYTES);

  // entries packed back to back, PTE_BYTES a power of two
  assign addr_o = base_i + (AW'(vpn_i) << SHIFT);
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 24,
  parameter int PAGE_BITS = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [VA_W-1:0]        req_va_i,
  output logic                   resp_valid_o,
  output logic                   resp_pa_valid_o,
  output logic                   resp_fault_o,
  output logic [PA_W-1:0]        resp_pa_o,
  output logic                   mem_req_valid_o,
  input  logic                   mem_req_ready_i,
  input  logic                   mem_rdata_valid_i,
  input  logic [PA_W-PAGE_BITS:0] mem_rdata_i,
  output logic [VA_W-PAGE_BITS-1:0] vpn_o
);
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int PTE_W = PPN_W + 1;

  xl_state_e        state_q;
  logic [VA_W-1:0]  va_q;
  logic             pte_v_q;
  logic [PPN_W-1:0] ppn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      pte_v_q <= 1'b0;
      ppn_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rdata_valid_i) begin
          pte_v_q <= mem_rdata_i[PTE_W-1];
          ppn_q   <= mem_rdata_i[PPN_W-1:0];
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_FETCH);
  assign resp_valid_o    = (state_q == ST_RESP);
  assign resp_pa_valid_o = resp_valid_o && pte_v_q;
  assign resp_fault_o    = resp_valid_o && !pte_v_q;
  assign resp_pa_o       = resp_pa_valid_o ? {ppn_q, va_q[PAGE_BITS-1:0]} : '0;
  assign vpn_o           = va_q[VA_W-1:PAGE_BITS];
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 24,
  parameter int PAGE_BITS = 12,
  parameter int MEM_AW    = 32,
  parameter int PTE_BYTES = 4,
  localparam int PPN_W    = PA_W - PAGE_BITS,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PTE_W    = PPN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [MEM_AW-1:0] base_d_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  output logic              resp_valid_o,
  output logic              resp_pa_valid_o,
  output logic              resp_fault_o,
  output logic [PA_W-1:0]   resp_pa_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [MEM_AW-1:0] mem_req_addr_o,
  input  logic              mem_rdata_valid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i
);
  logic [MEM_AW-1:0] base_q;
  logic [VPN_W-1:0]  vpn;

  pt_base_reg #(.AW(MEM_AW)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (base_we_i),
    .d_i    (base_d_i),
    .idle_i (req_ready_o),
    .q_o    (base_q)
  );

  pt_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_ctrl (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .req_valid_i       (req_valid_i),
    .req_ready_o       (req_ready_o),
    .req_va_i          (req_va_i),
    .resp_valid_o      (resp_valid_o),
    .resp_pa_valid_o   (resp_pa_valid_o),
    .resp_fault_o      (resp_fault_o),
    .resp_pa_o         (resp_pa_o),
    .mem_req_valid_o   (mem_req_valid_o),
    .mem_req_ready_i   (mem_req_ready_i),
    .mem_rdata_valid_i (mem_rdata_valid_i),
    .mem_rdata_i       (mem_rdata_i),
    .vpn_o             (vpn)
  );

  pt_addr_gen #(.VPN_W(VPN_W), .AW(MEM_AW), .PTE_BYTES(PTE_BYTES)) u_addr (
    .vpn_i  (vpn),
    .base_i (base_q),
    .addr_o (mem_req_addr_o)
  );
endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
  parameter int PA_W   = 24,
  parameter int MEM_AW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              resp_valid_o,
  input logic              resp_pa_valid_o,
  input logic              resp_fault_o,
  input logic [PA_W-1:0]   resp_pa_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [MEM_AW-1:0] mem_req_addr_o
);
  assert_fault_no_pa_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_fault_o |-> (resp_pa_o == '0));

  assert_one_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (resp_pa_valid_o != resp_fault_o));

  assert_flags_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> (!resp_pa_valid_o && !resp_fault_o));

  assert_resp_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);

  assert_busy_after_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_not_ready_in_resp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !req_ready_o);

  assert_fetch_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  assert_no_fetch_in_resp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !resp_valid_o);
endmodule

bind pt_xlate pt_xlate_chk #(.PA_W(PA_W), .MEM_AW(MEM_AW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .resp_valid_o    (resp_valid_o),
  .resp_pa_valid_o (resp_pa_valid_o),
  .resp_fault_o    (resp_fault_o),
  .resp_pa_o       (resp_pa_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o)
);

// File: tb/sim_pt_xlate.sv
`timescale 1ns/1ps
module sim_pt_xlate;
  localparam int VA_W = 12, PA_W = 10, PAGE_BITS = 4, MEM_AW = 12, PTE_BYTES = 2;
  localparam int PTE_W = PA_W - PAGE_BITS + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_we = 1'b0;
  logic [MEM_AW-1:0] base_d = '0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_va = '0;
  logic mem_ready = 1'b0;
  logic mem_rvalid = 1'b0;
  logic [PTE_W-1:0] mem_rdata = '0;
  logic req_ready, resp_valid, resp_pv, resp_flt, mem_valid;
  logic [PA_W-1:0] resp_pa;
  logic [MEM_AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  pt_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
             .MEM_AW(MEM_AW), .PTE_BYTES(PTE_BYTES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .base_we_i(base_we), .base_d_i(base_d),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .resp_valid_o(resp_valid), .resp_pa_valid_o(resp_pv), .resp_fault_o(resp_flt),
    .resp_pa_o(resp_pa), .mem_req_valid_o(mem_valid), .mem_req_ready_i(mem_ready),
    .mem_req_addr_o(mem_addr), .mem_rdata_valid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  logic [PTE_W-1:0] mem_w [0:2047];
  logic [MEM_AW-1:0] last_addr = '0;
  int rdly = 0, ddly = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // memory model: entry stored at byte address / 2
  initial begin
    forever begin
      @(negedge clk);
      mem_ready = 1'b0;
      mem_rvalid = 1'b0;
      if (rst_n && mem_valid) begin
        repeat (rdly) @(negedge clk);
        mem_ready = 1'b1;
        last_addr = mem_addr;
        @(negedge clk);
        mem_ready = 1'b0;
        repeat (ddly) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata = mem_w[last_addr[MEM_AW-1:1]];
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_base(input logic [MEM_AW-1:0] v);
    @(negedge clk);
    base_we = 1'b1;
    base_d = v;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic set_pte(input logic [MEM_AW-1:0] base, input int vpn, input bit v, input int ppn);
    logic [MEM_AW-1:0] a;
    a = base + MEM_AW'(vpn * PTE_BYTES);
    mem_w[a[MEM_AW-1:1]] = {v, 6'(ppn)};
  endtask

  logic pv, flt, rdy_ok, one_cyc;
  logic [PA_W-1:0] pa;
  int lat;

  task automatic run_xlate(input logic [VA_W-1:0] va, input int rd, input int dd,
                           input bit busy_we, input logic [MEM_AW-1:0] busy_base);
    rdly = rd;
    ddly = dd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    req_va = ~va;
    base_we = busy_we;
    base_d = busy_base;
    lat = 1;
    rdy_ok = 1'b1;
    while (!resp_valid && lat < 100) begin
      if (req_ready) rdy_ok = 1'b0;
      @(negedge clk);
      base_we = 1'b0;
      lat++;
    end
    if (req_ready) rdy_ok = 1'b0;
    pv = resp_pv;
    flt = resp_flt;
    pa = resp_pa;
    @(negedge clk);
    one_cyc = !resp_valid && !resp_pv && !resp_flt && req_ready;
  endtask

  task automatic t_reset;
    check("R1 req_ready", 32'(req_ready), 1);
    check("R1 resp_valid", 32'(resp_valid), 0);
    check("R1 flags", 32'({resp_pv, resp_flt}), 0);
    check("R1 mem_req_valid", 32'(mem_valid), 0);
  endtask

  task automatic t_hit;
    write_base(12'h400);
    set_pte(12'h400, 8'h12, 1, 6'h2A);
    run_xlate(12'h127, 0, 0, 0, '0);
    check("R2 addr", 32'(last_addr), 32'h424);
    check("R3 pa", 32'(pa), 32'h2A7);
    check("R3 pa_valid/fault", 32'({pv, flt}), 32'b10);
    check("R7 latency no stall", 32'(lat), 3);
    check("R5 one-cycle resp", 32'(one_cyc), 1);
    check("R6 ready low while busy", 32'(rdy_ok), 1);
  endtask

  task automatic t_fault_retry;
    set_pte(12'h400, 8'h33, 0, 6'h15);
    run_xlate(12'h33C, 1, 0, 0, '0);
    check("R4 fault flags", 32'({pv, flt}), 32'b01);
    check("R4 pa zero", 32'(pa), 0);
    check("R5 one-cycle fault", 32'(one_cyc), 1);
    set_pte(12'h400, 8'h33, 1, 6'h05);
    run_xlate(12'h33C, 0, 0, 0, '0);
    check("R9 retry hit", 32'({pv, flt}), 32'b10);
    check("R9 retry pa", 32'(pa), 32'h05C);
  endtask

  task automatic t_stalls;
    set_pte(12'h400, 8'h01, 1, 6'h11);
    run_xlate(12'h013, 3, 5, 0, '0);
    check("R7 latency stalled", 32'(lat), 11);
    check("R7 stalled pa", 32'(pa), 32'h113);
    check("R6 ready low in stalls", 32'(rdy_ok), 1);
    check("R2 addr stalled", 32'(last_addr), 32'h402);
  endtask

  task automatic t_corners;
    set_pte(12'h400, 8'hFF, 1, 6'h3F);
    run_xlate(12'hFFF, 0, 2, 0, '0);
    check("R2 addr top vpn", 32'(last_addr), 32'h5FE);
    check("R3 pa all ones", 32'(pa), 32'h3FF);
    set_pte(12'h400, 8'h00, 1, 6'h00);
    run_xlate(12'h000, 2, 0, 0, '0);
    check("R2 addr vpn0", 32'(last_addr), 32'h400);
    check("R3 pa zero hit", 32'({pv, flt, 10'(pa)}), 32'h800);
  endtask

  task automatic t_base;
    write_base(12'h600);
    set_pte(12'h600, 8'h12, 1, 6'h09);
    run_xlate(12'h12A, 0, 0, 0, '0);
    check("R8 idle base write used", 32'(last_addr), 32'h624);
    check("R8 new table pa", 32'(pa), 32'h09A);
    set_pte(12'h200, 8'h12, 1, 6'h30);
    run_xlate(12'h12A, 2, 1, 1, 12'h200);
    check("R8 busy write ignored now", 32'(last_addr), 32'h624);
    run_xlate(12'h12A, 0, 0, 0, '0);
    check("R8 busy write ignored later", 32'(last_addr), 32'h624);
    check("R8 pa still old table", 32'(pa), 32'h09A);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem_w[i] = '0;
    #12;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_hit;
    t_fault_retry;
    t_stalls;
    t_corners;
    t_base;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule